// File: doc/BRIEF.md
# Serial Receive Word Capture Port

This block collects one 13-bit two's complement sample from a serial data line and hands it to a downstream converter through a parallel holding latch. The serial data clock, the capture enable and the frame strobe are all treated as plain inputs sampled by one system clock. A data-clock fall is a sample that was high followed by a sample that was low. An enable rise is a sample that was low followed by a sample that was high. A rising edge on the enable arms a capture. The next 13 data-clock falls each shift in one bit, and every later fall is discarded. The frame strobe from the sequencer then copies a complete word into the latch and emits a one-cycle ready pulse. If the word is not complete when the strobe comes, the latch keeps its old contents and a short-frame flag is raised.

The control is a three-state machine:
- Idle: no capture is armed. An enable rise moves it to Shift.
- Shift: bits are being counted. The 13th fall moves it to Full. An enable rise stays in Shift and restarts the count.
- Full: a word is complete and further bits are dropped. An enable rise re-arms the capture and returns to Shift.

From every state an accepted frame strobe returns the machine to Idle. While power-down is high the machine holds its state and nothing is updated.

Top module: `rx_word_capture`

## Requirements
- R1: A synchronous reset clears the latch output to 0, clears the ready pulse and the short-frame flag, and empties the bit counter. An enable that is already high when reset ends does not count as a rising edge.
- R2: A bit is taken only on a data-clock fall, that is, high in one system-clock sample and low in the next. Rising data-clock edges and steady levels take no bit.
- R3: The first bit received after arming becomes word bit 12, the sign. Each following bit fills the next lower position, and the 13th bit lands in word bit 0.
- R4: After the 13th accepted bit, further data-clock falls are discarded until the capture is armed again.
- R5: Capture is armed only by an enable rise. Falls seen while no capture is armed are ignored, including while the enable stays high after a completed frame.
- R6: An enable rise during a partial capture restarts the count from zero. A data-clock fall in the same cycle as the arming edge is not taken.
- R7: A frame strobe that arrives with 13 bits captured loads the word into the latch. The ready output is high for exactly the one cycle after the strobe, and the short-frame flag is cleared.
- R8: A frame strobe that arrives with fewer than 13 bits captured leaves the latch unchanged, gives no ready pulse, and sets the short-frame flag until the next accepted strobe. The partial bits are discarded.
- R9: After any accepted strobe the machine is in Idle, so a new capture needs a fresh enable rise. A strobe wins over an enable rise that arrives in the same cycle, and that rise is lost.
- R10: While power-down is high, the state, the bit count, the partial word, the latch and the short-frame flag all hold, and strobes are ignored. When power-down is released, capture resumes from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_sdat | input | 1 | Serial data, sign bit first |
| rx_sclk | input | 1 | Serial data clock, sampled; bits are taken on its falls |
| rx_en | input | 1 | Capture enable; a rising edge arms a capture |
| frame_stb | input | 1 | Frame strobe from the sequencer, one cycle |
| pwr_dn | input | 1 | Power-down; freezes capture and latch |
| rx_word | output | 13 | Latched two's complement word |
| rx_ready | output | 1 | One-cycle pulse after the latch is loaded |
| rx_short | output | 1 | Last accepted strobe found an incomplete word |

## Verification
The assertions check on every cycle the properties that depend only on the strobe and the machine state:
- a strobe on a complete word loads the latch and pulses ready, and a strobe on an incomplete word holds the latch and raises the flag;
- ready never lasts two cycles;
- the latch changes only together with ready;
- power-down freezes the outputs;
- the bit count never passes 13.

Only the bench scenarios can show that the bits land MSB-first in the right positions. The same holds for extra bits after the 13th being dropped, rising data-clock edges being ignored, re-arming restarting the count, and a capture interrupted by power-down joining up with its remaining bits.

// File: rtl/rx_cap_pkg.sv
package rx_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/rx_edge_det.sv
// Detects one edge of a sampled level; the polarity is picked by a parameter.
module rx_edge_det #(
    parameter bit DETECT_RISE = 1'b1,
    parameter bit RST_LVL     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic edge_hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_LVL;
        else     prev_q <= lvl;
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_hit = lvl & ~prev_q;
        end else begin : g_fall
            assign edge_hit = prev_q & ~lvl;
        end
    endgenerate
endmodule

// File: rtl/rx_shift_cnt.sv
// Shift register with bit counter; new bits enter at the LSB.
module rx_shift_cnt #(
    parameter int WORD_W = 13,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] sreg,
    output logic [CNT_W-1:0]  bit_cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg    <= '0;
            bit_cnt <= '0;
        end else if (shift_en) begin
            sreg    <= {sreg[WORD_W-2:0], bit_in};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rx_out_latch.sv
// Holding latch, ready pulse and short-frame flag.
module rx_out_latch #(
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_ok,
    input  logic              full,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word_q,
    output logic              rdy,
    output logic              short_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            rdy     <= 1'b0;
            short_q <= 1'b0;
        end else begin
            rdy <= 1'b0;
            if (stb_ok) begin
                if (full) begin
                    word_q  <= din;
                    rdy     <= 1'b1;
                    short_q <= 1'b0;
                end else begin
                    short_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_word_capture.sv
module rx_word_capture
    import rx_cap_pkg::*;
#(
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_sdat,
    input  logic              rx_sclk,
    input  logic              rx_en,
    input  logic              frame_stb,
    input  logic              pwr_dn,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              rx_short
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    cap_state_e        state_q, state_d;
    logic              en_rise, clk_fall, last_bit;
    logic              arm, shift_en, stb_ok, full, clr;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  bit_cnt;

    rx_edge_det #(.DETECT_RISE(1'b1), .RST_LVL(1'b1)) u_en_edge (
        .clk(clk), .rst(rst), .lvl(rx_en), .edge_hit(en_rise)
    );

    rx_edge_det #(.DETECT_RISE(1'b0), .RST_LVL(1'b0)) u_clk_edge (
        .clk(clk), .rst(rst), .lvl(rx_sclk), .edge_hit(clk_fall)
    );

    assign last_bit = (bit_cnt == CNT_W'(WORD_W - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!pwr_dn) begin
            if (frame_stb) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE:  if (en_rise) state_d = ST_SHIFT;
                    ST_SHIFT: begin
                        if (en_rise)                    state_d = ST_SHIFT;
                        else if (clk_fall && last_bit)  state_d = ST_FULL;
                    end
                    ST_FULL:  if (en_rise) state_d = ST_SHIFT;
                    default:  state_d = ST_IDLE;
                endcase
            end
        end
    end

    // Control outputs
    always_comb begin
        stb_ok   = !pwr_dn && frame_stb;
        arm      = !pwr_dn && !frame_stb && en_rise;
        shift_en = !pwr_dn && !frame_stb && !en_rise && clk_fall
                   && (state_q == ST_SHIFT);
        full     = (state_q == ST_FULL);
        clr      = arm || stb_ok;
    end

    rx_shift_cnt #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst(rst), .clr(clr), .shift_en(shift_en),
        .bit_in(rx_sdat), .sreg(sreg), .bit_cnt(bit_cnt)
    );

    rx_out_latch #(.WORD_W(WORD_W)) u_latch (
        .clk(clk), .rst(rst), .stb_ok(stb_ok), .full(full), .din(sreg),
        .word_q(rx_word), .rdy(rx_ready), .short_q(rx_short)
    );
endmodule

// File: rtl/rx_word_capture_chk.sv
module rx_word_capture_chk
    import rx_cap_pkg::*;
#(
    parameter int WORD_W = 13,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic              pwr_dn,
    input cap_state_e        state_q,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_ready,
    input logic              rx_short
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rx_word == '0 && !rx_ready && !rx_short));

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));

    a_r7_load_full: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !pwr_dn && state_q == ST_FULL) |=> (rx_ready && !rx_short));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    a_r7_word_moves_with_ready: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> $stable(rx_word));

    a_r8_short_holds: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !pwr_dn && state_q != ST_FULL)
        |=> ($stable(rx_word) && rx_short && !rx_ready));

    a_r10_pd_freeze: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> ($stable(rx_word) && $stable(rx_short) && !rx_ready));
endmodule

bind rx_word_capture rx_word_capture_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .pwr_dn(pwr_dn),
    .state_q(state_q), .bit_cnt(bit_cnt), .rx_word(rx_word),
    .rx_ready(rx_ready), .rx_short(rx_short)
);

// File: tb/tb_rx_word_capture.sv
module tb_rx_word_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_sdat = 1'b0, rx_sclk = 1'b0, rx_en = 1'b1;
    logic        frame_stb = 1'b0, pwr_dn = 1'b0;
    logic [12:0] rx_word;
    logic        rx_ready, rx_short;

    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    logic [12:0] exp_q[$];

    always #4 clk = ~clk;

    rx_word_capture dut (
        .clk(clk), .rst(rst), .rx_sdat(rx_sdat), .rx_sclk(rx_sclk),
        .rx_en(rx_en), .frame_stb(frame_stb), .pwr_dn(pwr_dn),
        .rx_word(rx_word), .rx_ready(rx_ready), .rx_short(rx_short)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each ready pulse
    always @(negedge clk) begin
        if (!rst && rx_ready) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected ready", 32'(rx_word), 32'hFFFF_FFFF);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check("R3/R7 latched word", 32'(rx_word), 32'(e));
            end
        end
    end

    task automatic arm();
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin rx_sclk = 1'b1; rx_sdat = b; end
        @(negedge clk) rx_sclk = 1'b0;
    endtask

    task automatic send_rng(input logic [12:0] v, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) send_bit(v[i]);
    endtask

    task automatic strobe();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic expect_word(input logic [12:0] v);
        exp_q.push_back(v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 word after reset", 32'(rx_word), 32'h0);
        check("R1 ready after reset", 32'(rx_ready), 32'h0);
        check("R1 short after reset", 32'(rx_short), 32'h0);

        // R1/R5: enable high through reset is not an arming edge
        send_rng(13'h1FFF, 12, 0);
        strobe();
        @(negedge clk);
        check("R5 no capture without rise", 32'(rx_word), 32'h0);
        check("R5 short flag", 32'(rx_short), 32'h1);

        // R2/R3: basic frame, negative value
        arm();
        send_rng(13'h1A5C, 12, 0);
        expect_word(13'h1A5C);
        strobe();
        check("R7 ready one cycle after strobe", 32'(rx_ready), 32'h1);
        @(negedge clk);
        check("R7 ready drops", 32'(rx_ready), 32'h0);
        check("R7 short cleared", 32'(rx_short), 32'h0);

        // R4: three extra ones after the 13th bit
        arm();
        send_rng(13'h0F0F, 12, 0);
        send_rng(13'h1FFF, 2, 0);
        expect_word(13'h0F0F);
        strobe();
        @(negedge clk);
        check("R4 extra bits dropped", 32'(rx_word), 32'h0F0F);

        // R2: data toggles with clock low, then a lone rising edge
        arm();
        for (int i = 0; i < 4; i++) @(negedge clk) rx_sdat = ~rx_sdat;
        @(negedge clk) rx_sclk = 1'b1;
        @(negedge clk) rx_sdat = 1'b1;
        send_rng(13'h0B37, 12, 0);
        expect_word(13'h0B37);
        strobe();
        @(negedge clk);
        check("R2 only falls take bits", 32'(rx_word), 32'h0B37);

        // R6: re-arm mid-frame restarts the count
        arm();
        send_rng(13'h1FFF, 5, 0);
        arm();
        send_rng(13'h1234, 12, 0);
        expect_word(13'h1234);
        strobe();
        @(negedge clk);
        check("R6 re-arm restart", 32'(rx_word), 32'h1234);

        // R10: power-down in the middle of a frame
        arm();
        send_rng(13'h0ACE, 12, 6);
        @(negedge clk) pwr_dn = 1'b1;
        send_rng(13'h1FFF, 2, 0);
        strobe();
        @(negedge clk);
        check("R10 word held in power-down", 32'(rx_word), 32'h1234);
        check("R10 short held in power-down", 32'(rx_short), 32'h0);
        pwr_dn = 1'b0;
        send_rng(13'h0ACE, 5, 0);
        expect_word(13'h0ACE);
        strobe();
        @(negedge clk);
        check("R10 capture resumes", 32'(rx_word), 32'h0ACE);

        // R8: short frame holds the latch
        arm();
        send_rng(13'h1555, 12, 8);
        strobe();
        check("R8 no ready on short frame", 32'(rx_ready), 32'h0);
        @(negedge clk);
        check("R8 latch held", 32'(rx_word), 32'h0ACE);
        check("R8 short flag set", 32'(rx_short), 32'h1);

        // R5/R9: bits after a strobe without re-arm are ignored
        send_rng(13'h1555, 12, 0);
        strobe();
        @(negedge clk);
        check("R9 no capture after strobe", 32'(rx_word), 32'h0ACE);

        // R9: strobe beats an enable rise in the same cycle
        arm();
        send_rng(13'h1F01, 12, 0);
        expect_word(13'h1F01);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) begin rx_en = 1'b1; frame_stb = 1'b1; end
        @(negedge clk) frame_stb = 1'b0;
        check("R9 short clear on full strobe", 32'(rx_short), 32'h0);
        send_rng(13'h0555, 12, 0);
        strobe();
        @(negedge clk);
        check("R9 same-cycle rise lost", 32'(rx_word), 32'h1F01);
        check("R9 short after lost rise", 32'(rx_short), 32'h1);
        arm();
        send_rng(13'h0555, 12, 0);
        expect_word(13'h0555);
        strobe();
        @(negedge clk);
        check("R5 fresh rise captures", 32'(rx_word), 32'h0555);

        check("R7 all expected words seen", 32'(exp_q.size()), 32'h0);

        // R1: reset mid-operation
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 reset clears latch", 32'(rx_word), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule